// File: doc/BRIEF.md
# Decode Group Steering

This block sits between an instruction queue and a bank of asymmetric decoders. Each cycle it sees a window of up to four instructions whose lengths and classes are already known. Each instruction carries a class tag and a micro-op count. The block decides how many of them form this cycle's decode group. It reports which slots were taken, how many instructions the queue should drop, and how many micro-ops the hardware decoders produce.

Only the leading decoder can expand an instruction into several micro-ops, so a multi-op instruction stops the group unless it is at the head. Some instructions need more micro-ops than the leading decoder can produce. When such an instruction reaches the head, it goes to a microcode sequencer as a single-instruction group. The block then holds off all further decoding until the sequencer signals that its stream is finished.

Top module: `dec_group_steer`

## Requirements
- R1: The accept mask is always a contiguous run of valid slots starting at slot 0, with no gap. An invalid slot ends the group even when later slots are valid. No more than SLOTS (4) instructions are accepted in a cycle.
- R2: Class encoding is 0 = simple, 1 = complex, 2 = microcoded, 3 = reserved. Slot 0 may be accepted with any class. Slots 1 to 3 are accepted only when their class is simple (0).
- R3: A non-simple instruction in slot k > 0 ends the group just before it. The accept mask then covers slots 0 to k-1 only.
- R4: A simple instruction adds exactly one micro-op to uop_total_o, whatever its count field holds.
- R5: A complex instruction (class 1) with a count field of 1 to 4 adds that count to uop_total_o.
- R6: An instruction goes to microcode if it has class 2 or 3, or if it has class 1 with a count of 0 or above 4. When it is in slot 0, it is accepted alone: accept mask 0001, ucode_req_o high in that same cycle, and no micro-ops added to uop_total_o.
- R7: From the cycle after ucode_req_o, stall_o is high. While stall_o is high, the mask, consumed count, micro-op total and request are all zero. Decoding resumes in the cycle after ucode_done_i is sampled high while stalled. ucode_done_i has no effect while not stalled.
- R8: consumed_o equals the number of accepted slots.
- R9: After reset, stall_o is low and a window of valid simple instructions is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_valid_i | input | 4 | Per-slot valid |
| slot_class_i | input | 4x2 | Per-slot class tag (0 simple, 1 complex, 2 microcoded, 3 reserved) |
| slot_ucnt_i | input | 4x3 | Per-slot micro-op count |
| ucode_done_i | input | 1 | Sequencer has finished its stream |
| accept_o | output | 4 | Slots decoded this cycle |
| consumed_o | output | 3 | Number of instructions taken from the queue |
| uop_total_o | output | 3 | Micro-ops produced by the hardware decoders |
| ucode_req_o | output | 1 | Start the microcode sequencer on slot 0 |
| stall_o | output | 1 | Decoding held while the sequencer streams |

## Verification
The only internal state is the sequencer-busy flag. If it is set wrongly, it shows up one cycle after the faulty edge: either stall_o is high and the mask is empty when instructions should flow, or decoding continues after a request. Errors in grouping are combinational. They show at the mask, consumed count and micro-op total in the same cycle as the window that triggers them. A reference model recomputes those three values for every window and checks them each cycle, so a fault appears at the first window that exercises it.

// File: rtl/dgs_pkg.sv
package dgs_pkg;
  typedef enum logic [1:0] {
    CLS_SIMPLE  = 2'd0,
    CLS_COMPLEX = 2'd1,
    CLS_MCODE   = 2'd2,
    CLS_RSVD    = 2'd3
  } ins_class_e;
endpackage

// File: rtl/dgs_slot_class.sv
module dgs_slot_class
  import dgs_pkg::*;
#(
  parameter int CNT_W    = 3,
  parameter int CPLX_MAX = 4
) (
  input  logic             valid_i,
  input  ins_class_e       cls_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             simple_o,
  output logic             cplx_o,
  output logic             mcode_o,
  output logic [CNT_W-1:0] uops_o
);
  logic cplx_fit;

  always_comb begin
    cplx_fit = (cls_i == CLS_COMPLEX) && (cnt_i != '0) && (int'(cnt_i) <= CPLX_MAX);
    simple_o = valid_i && (cls_i == CLS_SIMPLE);
    cplx_o   = valid_i && cplx_fit;
    mcode_o  = valid_i && (cls_i != CLS_SIMPLE) && !cplx_fit;
    if (simple_o)    uops_o = CNT_W'(1);
    else if (cplx_o) uops_o = cnt_i;
    else             uops_o = '0;
  end
endmodule

// File: rtl/dgs_group_form.sv
module dgs_group_form #(
  parameter int SLOTS = 4,
  parameter int CNT_W = 3,
  parameter int SUM_W = 3,
  parameter int CONS_W = 3
) (
  input  logic                        en_i,
  input  logic [SLOTS-1:0]            simple_i,
  input  logic [SLOTS-1:0]            cplx_i,
  input  logic [SLOTS-1:0]            mcode_i,
  input  logic [SLOTS-1:0][CNT_W-1:0] uops_i,
  output logic [SLOTS-1:0]            accept_o,
  output logic [CONS_W-1:0]           consumed_o,
  output logic [SUM_W-1:0]            uop_total_o,
  output logic                        mcode_take_o
);
  logic [SLOTS-1:0] run;

  // head slot takes any class; followers chain only on simple
  assign run[0] = en_i && (simple_i[0] || cplx_i[0] || mcode_i[0]);

  for (genvar k = 1; k < SLOTS; k++) begin : g_chain
    assign run[k] = run[k-1] && simple_i[k] && !mcode_i[0];
  end

  always_comb begin
    uop_total_o = '0;
    for (int k = 0; k < SLOTS; k++)
      if (run[k]) uop_total_o = uop_total_o + SUM_W'(uops_i[k]);
  end

  assign accept_o     = run;
  assign consumed_o   = CONS_W'($countones(run));
  assign mcode_take_o = en_i && mcode_i[0];
endmodule

// File: rtl/dgs_ucode_ctl.sv
module dgs_ucode_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic done_i,
  output logic busy_o
);
  logic busy_q, busy_d;

  always_comb begin
    busy_d = busy_q;
    if (!busy_q && take_i) busy_d = 1'b1;
    else if (busy_q && done_i) busy_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b0;
    else         busy_q <= busy_d;
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/dec_group_steer.sv
module dec_group_steer
  import dgs_pkg::*;
#(
  parameter int SLOTS    = 4,
  parameter int CNT_W    = 3,
  parameter int CPLX_MAX = 4,
  localparam int SUM_W   = $clog2(CPLX_MAX + SLOTS),
  localparam int CONS_W  = $clog2(SLOTS + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [SLOTS-1:0]            slot_valid_i,
  input  logic [SLOTS-1:0][1:0]       slot_class_i,
  input  logic [SLOTS-1:0][CNT_W-1:0] slot_ucnt_i,
  input  logic                        ucode_done_i,
  output logic [SLOTS-1:0]            accept_o,
  output logic [CONS_W-1:0]           consumed_o,
  output logic [SUM_W-1:0]            uop_total_o,
  output logic                        ucode_req_o,
  output logic                        stall_o
);
  logic [SLOTS-1:0]            simple, cplx, mcode;
  logic [SLOTS-1:0][CNT_W-1:0] uops;
  logic                        busy, take;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    dgs_slot_class #(.CNT_W(CNT_W), .CPLX_MAX(CPLX_MAX)) u_cls (
      .valid_i  (slot_valid_i[k]),
      .cls_i    (ins_class_e'(slot_class_i[k])),
      .cnt_i    (slot_ucnt_i[k]),
      .simple_o (simple[k]),
      .cplx_o   (cplx[k]),
      .mcode_o  (mcode[k]),
      .uops_o   (uops[k])
    );
  end

  dgs_group_form #(.SLOTS(SLOTS), .CNT_W(CNT_W), .SUM_W(SUM_W), .CONS_W(CONS_W)) u_form (
    .en_i         (!busy),
    .simple_i     (simple),
    .cplx_i       (cplx),
    .mcode_i      (mcode),
    .uops_i       (uops),
    .accept_o     (accept_o),
    .consumed_o   (consumed_o),
    .uop_total_o  (uop_total_o),
    .mcode_take_o (take)
  );

  dgs_ucode_ctl u_ctl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (take),
    .done_i (ucode_done_i),
    .busy_o (busy)
  );

  assign ucode_req_o = take;
  assign stall_o     = busy;
endmodule

// File: rtl/dec_group_steer_chk.sv
module dec_group_steer_chk #(
  parameter int SLOTS  = 4,
  parameter int CONS_W = 3
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [SLOTS-1:0]      slot_valid_i,
  input logic [SLOTS-1:0][1:0] slot_class_i,
  input logic                  ucode_done_i,
  input logic [SLOTS-1:0]      accept_o,
  input logic [CONS_W-1:0]     consumed_o,
  input logic                  ucode_req_o,
  input logic                  stall_o
);
  logic later_bad;
  always_comb begin
    later_bad = 1'b0;
    for (int k = 1; k < SLOTS; k++)
      if (accept_o[k] && slot_class_i[k] != 2'd0) later_bad = 1'b1;
  end

  assert_prefix_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((accept_o & ~slot_valid_i) == '0) && (((accept_o + 1'b1) & accept_o) == '0));
  assert_follow_simple_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !later_bad);
  assert_req_alone_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ucode_req_o |-> (accept_o == SLOTS'(1)));
  assert_req_stalls_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ucode_req_o |=> stall_o);
  assert_stall_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (accept_o == '0) && !ucode_req_o);
  assert_done_resumes_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && ucode_done_i) |=> !stall_o);
  assert_count_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(consumed_o) == $countones(accept_o));
endmodule

bind dec_group_steer dec_group_steer_chk #(.SLOTS(SLOTS), .CONS_W(CONS_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .slot_valid_i (slot_valid_i),
  .slot_class_i (slot_class_i),
  .ucode_done_i (ucode_done_i),
  .accept_o     (accept_o),
  .consumed_o   (consumed_o),
  .ucode_req_o  (ucode_req_o),
  .stall_o      (stall_o)
);

// File: tb/dec_group_steer_test.sv
`timescale 1ns/1ps
module dec_group_steer_test;
  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [3:0]      vld = '0;
  logic [3:0][1:0] cls = '0;
  logic [3:0][2:0] cnt = '0;
  logic            done = 1'b0;
  logic [3:0]      acc;
  logic [2:0]      cons, uops;
  logic            req, stall;

  int checks = 0, errors = 0;
  bit m_busy = 0;

  always #4 clk = ~clk;

  dec_group_steer uut (
    .clk_i(clk), .rst_ni(rst_n), .slot_valid_i(vld), .slot_class_i(cls),
    .slot_ucnt_i(cnt), .ucode_done_i(done), .accept_o(acc), .consumed_o(cons),
    .uop_total_o(uops), .ucode_req_o(req), .stall_o(stall)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference of one cycle
  task automatic step(logic [3:0] v, logic [3:0][1:0] c, logic [3:0][2:0] n, logic d);
    int e_acc, e_cons, e_uops, e_req;
    @(negedge clk);
    vld = v; cls = c; cnt = n; done = d;
    #1;
    e_acc = 0; e_cons = 0; e_uops = 0; e_req = 0;
    if (!m_busy) begin
      for (int k = 0; k < 4; k++) begin
        bit simple, fits;
        if (!v[k]) break;
        simple = (c[k] == 2'd0);
        fits = (c[k] == 2'd1) && (n[k] >= 1) && (n[k] <= 4);
        if (k == 0 && !simple && !fits) begin
          e_acc = 1; e_cons = 1; e_req = 1;
          break;
        end
        if (k > 0 && !simple) break;
        e_acc |= (1 << k); e_cons++;
        e_uops += simple ? 1 : int'(n[k]);
      end
    end
    chk("R1 accept mask", int'(acc), e_acc);
    chk("R8 consumed", int'(cons), e_cons);
    chk("R5 uop total", int'(uops), e_uops);
    chk("R6 ucode request", int'(req), e_req);
    chk("R7 stall", int'(stall), int'(m_busy));
    if (m_busy) m_busy = !d;
    else        m_busy = (e_req != 0);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 stall in reset", int'(stall), 0);
    rst_n = 1'b1;
    // R9: simples flow immediately; R4: count field ignored on simple
    step(4'b1111, '{2'd0, 2'd0, 2'd0, 2'd0}, '{3'd7, 3'd0, 3'd5, 3'd7}, 1'b0);
    // R5: complex head with 3 ops plus three simples
    step(4'b1111, '{2'd0, 2'd0, 2'd0, 2'd1}, '{3'd1, 3'd1, 3'd1, 3'd3}, 1'b0);
    // R3: complex in slot 2 ends group after slot 1
    step(4'b1111, '{2'd0, 2'd1, 2'd0, 2'd0}, '{3'd1, 3'd2, 3'd1, 3'd1}, 1'b0);
    // R3/R2: microcoded in slot 1 ends group after slot 0
    step(4'b1111, '{2'd0, 2'd0, 2'd2, 2'd1}, '{3'd1, 3'd1, 3'd1, 3'd4}, 1'b0);
    // R1: gap in valid stops the group
    step(4'b1011, '{2'd0, 2'd0, 2'd0, 2'd0}, '{3'd1, 3'd1, 3'd1, 3'd1}, 1'b0);
    // R7: done while idle has no effect
    step(4'b0011, '{2'd0, 2'd0, 2'd0, 2'd0}, '{3'd1, 3'd1, 3'd1, 3'd1}, 1'b1);
    // R6: complex with count 0 at head goes to microcode
    step(4'b1111, '{2'd0, 2'd0, 2'd0, 2'd1}, '{3'd1, 3'd1, 3'd1, 3'd0}, 1'b0);
    // R7: held while streaming, then resume
    step(4'b1111, '{2'd0, 2'd0, 2'd0, 2'd0}, '{3'd1, 3'd1, 3'd1, 3'd1}, 1'b0);
    step(4'b1111, '{2'd0, 2'd0, 2'd0, 2'd0}, '{3'd1, 3'd1, 3'd1, 3'd1}, 1'b1);
    step(4'b1111, '{2'd0, 2'd0, 2'd0, 2'd0}, '{3'd1, 3'd1, 3'd1, 3'd1}, 1'b0);
    // R6: complex count above 4, then reserved class
    step(4'b0001, '{2'd0, 2'd0, 2'd0, 2'd1}, '{3'd0, 3'd0, 3'd0, 3'd5}, 1'b1);
    step(4'b0001, '{2'd0, 2'd0, 2'd0, 2'd0}, '{3'd0, 3'd0, 3'd0, 3'd1}, 1'b1);
    step(4'b0001, '{2'd0, 2'd0, 2'd0, 2'd3}, '{3'd0, 3'd0, 3'd0, 3'd1}, 1'b0);
    step(4'b0000, '0, '0, 1'b1);
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] rv;
      logic [3:0][1:0] rc;
      logic [3:0][2:0] rn;
      rv = ($urandom % 3 == 0) ? 4'($urandom) : 4'b1111;
      for (int k = 0; k < 4; k++) begin
        rc[k] = ($urandom % 2 == 0) ? 2'd0 : 2'($urandom);
        rn[k] = 3'($urandom);
      end
      step(rv, rc, rn, ($urandom % 4) == 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule